// File: doc/BRIEF.md
# Machine Status Register Unit

This block owns the 32-bit machine status register of a small RISC core, the word that holds the interrupt and exception enables, the in-progress flags, the user and virtual mode bits with their saved copies, and the arithmetic carry. The decode stage hands it a special-register operation as the raw 16-bit immediate plus one instruction bit. Alongside come operand B, the ra register value, the address of the current instruction, an ALU carry with its write strobe, and a strobe that marks the completion of one of three return kinds.

Set-bits and clear-bits operations read out the old status word on the rd path in the same cycle and apply their mask at the next clock edge. Move-to and move-from operations address special registers by a 14-bit number. A window of 256 numbers is passed untouched to an external memory-management port. Return completion restores the user and virtual mode bits from their saved copies and adjusts the enable or in-progress bit that belongs to the return kind. A one-cycle pulse reports every applied update.

Top module: `msr_unit`

## Requirements
- R1: After reset the status word reads 0x00000400, state_chg is 0 and carry_out is 0; bit 10 reads 1 at all times after reset, whatever value is written.
- R2: With sr_valid high, sr_imm[15]=0 and sr_clr_sel=0 (set mode), rd_we is 1 and rd_data equals the current status word in the same cycle; after the next edge the status word is old OR opb OR 0x400.
- R3: In clear mode (sr_imm[15]=0, sr_clr_sel=1) rd_data returns the old word in the same cycle; after the next edge the status word is (old AND NOT opb) OR 0x400.
- R4: A move-to (sr_imm[15]=1, sr_imm[14]=1) with number sr_imm[13:0]=1 loads ra_val OR 0x400. A move-to any other local number leaves the status word unchanged, and rd_we stays 0.
- R5: A move-from (sr_imm[15]=1, sr_imm[14]=0) sets rd_we to 1 in the same cycle. Number 0 returns cur_pc, number 1 returns the status word, and any other local number returns 0.
- R6: Numbers 0x1000 to 0x10FF inclusive raise mmu_req with mmu_we=sr_imm[14], mmu_idx=sr_imm[7:0] and mmu_wdata=ra_val. A move-from in this window returns mmu_rdata on rd_data, and a move-to in this window does not touch the status word. Numbers 0x0FFF and 0x1100 are local.
- R7: carry_out equals bit 31 of the status word; carry_we writes carry_in into bit 31 and bit 2 together.
- R8: ret_done with ret_kind=01 (interrupt) sets bit 1. It copies bit 12 into bit 11 and bit 14 into bit 13, and leaves the other bits unchanged.
- R9: ret_done with ret_kind=10 (break) clears bit 3 and restores bits 11 and 13 as in R8.
- R10: ret_done with ret_kind=11 (exception) sets bit 8, clears bit 9 and restores bits 11 and 13 as in R8. ret_kind=00 has no effect.
- R11: state_chg is 1 in exactly the cycle after an update was applied (set, clear, move-to number 1, return kinds 01 to 11, carry write), even when the value does not change, and is 0 otherwise.
- R12: When several updates arrive in one cycle, a set, clear or move-to-number-1 operation wins over a return, and a return wins over a carry write. The losing updates are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_valid | input | 1 | Special-register operation present this cycle |
| sr_imm | input | 16 | Immediate: [15] move mode, [14] move-to, [13:0] number |
| sr_clr_sel | input | 1 | In set/clear mode, 1 selects clear |
| opb | input | 32 | Operand B, mask for set/clear |
| ra_val | input | 32 | ra value for move-to |
| cur_pc | input | 32 | Address of the current instruction |
| carry_we | input | 1 | Carry write strobe |
| carry_in | input | 1 | Carry value from the ALU |
| ret_done | input | 1 | Return completion strobe |
| ret_kind | input | 2 | 01 interrupt, 10 break, 11 exception |
| mmu_rdata | input | 32 | Read data from the MMU port |
| msr | output | 32 | Current status word |
| carry_out | output | 1 | Current carry |
| rd_data | output | 32 | Data for rd |
| rd_we | output | 1 | rd write enable |
| mmu_req | output | 1 | Access to the MMU window |
| mmu_we | output | 1 | MMU access is a write |
| mmu_idx | output | 8 | Register index within the MMU window |
| mmu_wdata | output | 32 | MMU write data |
| state_chg | output | 1 | One-cycle pulse after an applied update |

## Verification
The assertions for the return, carry and MMU cases take for granted that, in the cycle they look at, no higher-priority update arrives. They state this as an explicit precondition (no sr_valid, or no return and no carry), so an overlapping cycle simply falls outside them. The directed stimulus issues one operation per cycle except in the cycle that exercises R12. The random phase mixes all inputs freely, and a cycle-by-cycle reference model in the bench covers that phase, while the assertions only fire on cycles that meet their preconditions.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int B_IE  = 1;
  localparam int B_C   = 2;
  localparam int B_BIP = 3;
  localparam int B_EE  = 8;
  localparam int B_EIP = 9;
  localparam int B_VER = 10;
  localparam int B_UM  = 11;
  localparam int B_UMS = 12;
  localparam int B_VM  = 13;
  localparam int B_VMS = 14;

  typedef enum logic [2:0] {
    SA_NONE,
    SA_SET,
    SA_CLR,
    SA_TO_MSR,
    SA_TO_OTHER,
    SA_FROM,
    SA_MMU
  } sr_act_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'b00,
    RK_INTR = 2'b01,
    RK_BRK  = 2'b10,
    RK_EXC  = 2'b11
  } ret_kind_e;
endpackage

// File: rtl/msr_op_decode.sv
module msr_op_decode
  import msr_pkg::*;
#(
  parameter int SR_NUM_W  = 14,
  parameter int PAGE_W    = 6,
  parameter int MMU_PAGE  = 16
) (
  input  logic                sr_valid,
  input  logic [SR_NUM_W+1:0] sr_imm,
  input  logic                sr_clr_sel,
  output sr_act_e             act,
  output logic [SR_NUM_W-1:0] num
);
  localparam int MODE_BIT = SR_NUM_W + 1;
  localparam int DIR_BIT  = SR_NUM_W;
  localparam logic [PAGE_W-1:0] PAGE_V = PAGE_W'(MMU_PAGE);

  logic in_mmu;

  always_comb begin
    num    = sr_imm[SR_NUM_W-1:0];
    in_mmu = (num[SR_NUM_W-1 -: PAGE_W] == PAGE_V);
    if (!sr_valid) begin
      act = SA_NONE;
    end else if (!sr_imm[MODE_BIT]) begin
      act = sr_clr_sel ? SA_CLR : SA_SET;
    end else if (in_mmu) begin
      act = SA_MMU;
    end else if (sr_imm[DIR_BIT]) begin
      act = (num == SR_NUM_W'(1)) ? SA_TO_MSR : SA_TO_OTHER;
    end else begin
      act = SA_FROM;
    end
  end
endmodule

// File: rtl/msr_ret_restore.sv
module msr_ret_restore
  import msr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur,
  input  logic              ret_done,
  input  logic [1:0]        ret_kind,
  output logic [DATA_W-1:0] val,
  output logic              hit
);
  always_comb begin
    val        = cur;
    val[B_UM]  = cur[B_UMS];
    val[B_VM]  = cur[B_VMS];
    hit        = ret_done && (ret_kind != RK_NONE);
    case (ret_kind)
      RK_INTR: val[B_IE] = 1'b1;
      RK_BRK:  val[B_BIP] = 1'b0;
      RK_EXC: begin
        val[B_EE]  = 1'b1;
        val[B_EIP] = 1'b0;
      end
      default: val = cur;
    endcase
  end
endmodule

// File: rtl/msr_next_sel.sv
module msr_next_sel
  import msr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sr_act_e           act,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] ra_val,
  input  logic              ret_hit,
  input  logic [DATA_W-1:0] ret_val,
  input  logic              carry_we,
  input  logic              carry_in,
  output logic [DATA_W-1:0] nxt,
  output logic              upd
);
  localparam int NCARRY = 2;
  localparam int CARRY_POS [NCARRY] = '{B_C, DATA_W - 1};
  localparam logic [DATA_W-1:0] VER_MASK = DATA_W'(1) << B_VER;

  logic [DATA_W-1:0] carry_val;

  always_comb begin
    carry_val = cur;
    for (int i = 0; i < NCARRY; i++) begin
      carry_val[CARRY_POS[i]] = carry_in;
    end
  end

  always_comb begin
    upd = 1'b1;
    unique case (act)
      SA_SET:    nxt = cur | opb;
      SA_CLR:    nxt = cur & ~opb;
      SA_TO_MSR: nxt = ra_val;
      default: begin
        if (ret_hit)       nxt = ret_val;
        else if (carry_we) nxt = carry_val;
        else begin
          nxt = cur;
          upd = 1'b0;
        end
      end
    endcase
    nxt = nxt | VER_MASK;
  end
endmodule

// File: rtl/msr_unit.sv
module msr_unit
  import msr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SR_NUM_W = 14,
  parameter int PAGE_W   = 6,
  parameter int MMU_PAGE = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sr_valid,
  input  logic [SR_NUM_W+1:0]        sr_imm,
  input  logic                       sr_clr_sel,
  input  logic [DATA_W-1:0]          opb,
  input  logic [DATA_W-1:0]          ra_val,
  input  logic [DATA_W-1:0]          cur_pc,
  input  logic                       carry_we,
  input  logic                       carry_in,
  input  logic                       ret_done,
  input  logic [1:0]                 ret_kind,
  input  logic [DATA_W-1:0]          mmu_rdata,
  output logic [DATA_W-1:0]          msr,
  output logic                       carry_out,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_we,
  output logic                       mmu_req,
  output logic                       mmu_we,
  output logic [SR_NUM_W-PAGE_W-1:0] mmu_idx,
  output logic [DATA_W-1:0]          mmu_wdata,
  output logic                       state_chg
);
  localparam int IDX_W = SR_NUM_W - PAGE_W;
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << B_VER;

  sr_act_e             act;
  logic [SR_NUM_W-1:0] num;
  logic [DATA_W-1:0]   msr_q, msr_d;
  logic                chg_q;
  logic                upd;
  logic [DATA_W-1:0]   ret_val;
  logic                ret_hit;

  msr_op_decode #(.SR_NUM_W(SR_NUM_W), .PAGE_W(PAGE_W), .MMU_PAGE(MMU_PAGE)) u_dec (
    .sr_valid   (sr_valid),
    .sr_imm     (sr_imm),
    .sr_clr_sel (sr_clr_sel),
    .act        (act),
    .num        (num)
  );

  msr_ret_restore #(.DATA_W(DATA_W)) u_ret (
    .cur      (msr_q),
    .ret_done (ret_done),
    .ret_kind (ret_kind),
    .val      (ret_val),
    .hit      (ret_hit)
  );

  msr_next_sel #(.DATA_W(DATA_W)) u_nxt (
    .act      (act),
    .cur      (msr_q),
    .opb      (opb),
    .ra_val   (ra_val),
    .ret_hit  (ret_hit),
    .ret_val  (ret_val),
    .carry_we (carry_we),
    .carry_in (carry_in),
    .nxt      (msr_d),
    .upd      (upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_q <= RESET_VAL;
    end else if (upd) begin
      msr_q <= msr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= upd;
    end
  end

  always_comb begin
    rd_we   = 1'b0;
    rd_data = '0;
    case (act)
      SA_SET, SA_CLR: begin
        rd_we   = 1'b1;
        rd_data = msr_q;
      end
      SA_FROM: begin
        rd_we = 1'b1;
        if (num == SR_NUM_W'(0))      rd_data = cur_pc;
        else if (num == SR_NUM_W'(1)) rd_data = msr_q;
        else                          rd_data = '0;
      end
      SA_MMU: begin
        rd_we   = !sr_imm[SR_NUM_W];
        rd_data = mmu_rdata;
      end
      default: begin
        rd_we   = 1'b0;
        rd_data = '0;
      end
    endcase
  end

  assign mmu_req   = (act == SA_MMU);
  assign mmu_we    = mmu_req && sr_imm[SR_NUM_W];
  assign mmu_idx   = num[IDX_W-1:0];
  assign mmu_wdata = ra_val;
  assign msr       = msr_q;
  assign carry_out = msr_q[DATA_W-1];
  assign state_chg = chg_q;
endmodule

// File: rtl/msr_unit_chk.sv
module msr_unit_chk
  import msr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_valid,
  input logic [15:0]       sr_imm,
  input logic              sr_clr_sel,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] ra_val,
  input logic              carry_we,
  input logic              carry_in,
  input logic              ret_done,
  input logic [1:0]        ret_kind,
  input logic [DATA_W-1:0] msr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_we,
  input logic              mmu_req,
  input logic              state_chg
);
  localparam logic [DATA_W-1:0] VER_MASK = DATA_W'(1) << B_VER;

  AST_VER_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    msr[B_VER]); // R1

  AST_SETCLR_OLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && !sr_imm[15]) |-> (rd_we && rd_data == msr)); // R2

  AST_SET_MASK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && !sr_imm[15] && !sr_clr_sel) |=> ((msr & $past(opb)) == $past(opb))); // R2

  AST_CLR_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && !sr_imm[15] && sr_clr_sel) |=> ((msr & $past(opb) & ~VER_MASK) == '0)); // R3

  AST_MOVE_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && sr_imm[15:14] == 2'b11 && sr_imm[13:0] == 14'd1) |=> (msr == ($past(ra_val) | VER_MASK))); // R4

  AST_MMU_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_req && !ret_done && !carry_we) |=> (msr == $past(msr))); // R6

  AST_CARRY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_we && !sr_valid && !ret_done) |=> (msr[DATA_W-1] == $past(carry_in) && msr[B_C] == $past(carry_in))); // R7

  AST_RTI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && ret_kind == 2'b01 && !sr_valid) |=>
      (msr[B_IE] && msr[B_UM] == $past(msr[B_UMS]) && msr[B_VM] == $past(msr[B_VMS]))); // R8

  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msr) |-> state_chg); // R11
endmodule

bind msr_unit msr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sr_valid   (sr_valid),
  .sr_imm     (sr_imm),
  .sr_clr_sel (sr_clr_sel),
  .opb        (opb),
  .ra_val     (ra_val),
  .carry_we   (carry_we),
  .carry_in   (carry_in),
  .ret_done   (ret_done),
  .ret_kind   (ret_kind),
  .msr        (msr),
  .rd_data    (rd_data),
  .rd_we      (rd_we),
  .mmu_req    (mmu_req),
  .state_chg  (state_chg)
);

// File: tb/sim_msr_unit.sv
module sim_msr_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sr_valid;
  logic [15:0] sr_imm;
  logic        sr_clr_sel;
  logic [31:0] opb, ra_val, cur_pc, mmu_rdata;
  logic        carry_we, carry_in, ret_done;
  logic [1:0]  ret_kind;
  logic [31:0] msr, rd_data, mmu_wdata;
  logic        carry_out, rd_we, mmu_req, mmu_we, state_chg;
  logic [7:0]  mmu_idx;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_msr;
  logic        m_chg;
  string       m_tag;

  always #(CLK_P/2) clk = ~clk;

  msr_unit u0 (
    .clk(clk), .rst_n(rst_n), .sr_valid(sr_valid), .sr_imm(sr_imm),
    .sr_clr_sel(sr_clr_sel), .opb(opb), .ra_val(ra_val), .cur_pc(cur_pc),
    .carry_we(carry_we), .carry_in(carry_in), .ret_done(ret_done),
    .ret_kind(ret_kind), .mmu_rdata(mmu_rdata), .msr(msr),
    .carry_out(carry_out), .rd_data(rd_data), .rd_we(rd_we),
    .mmu_req(mmu_req), .mmu_we(mmu_we), .mmu_idx(mmu_idx),
    .mmu_wdata(mmu_wdata), .state_chg(state_chg)
  );

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic step(input string tg, input logic v, input logic [15:0] im, input logic cl,
                      input logic [31:0] b, input logic [31:0] a, input logic [31:0] p,
                      input logic cw, input logic ci, input logic rdn, input logic [1:0] rk,
                      input logic [31:0] mr);
    int unsigned num;
    logic mmu_hit, sc, frm, e_we, upd;
    logic [31:0] e_rd, n;
    @(negedge clk);
    chk(m_tag, "msr", msr, m_msr);
    chk("R11", "state_chg", {31'b0, state_chg}, {31'b0, m_chg});
    chk("R7", "carry_out", {31'b0, carry_out}, {31'b0, m_msr[31]});
    sr_valid = v; sr_imm = im; sr_clr_sel = cl; opb = b; ra_val = a; cur_pc = p;
    carry_we = cw; carry_in = ci; ret_done = rdn; ret_kind = rk; mmu_rdata = mr;
    #1;
    num     = im[13:0];
    mmu_hit = v && im[15] && num >= 32'h1000 && num <= 32'h10FF;
    sc      = v && !im[15];
    frm     = v && im[15] && !im[14] && !mmu_hit;
    e_we    = sc || frm || (mmu_hit && !im[14]);
    if (sc)           e_rd = m_msr;
    else if (mmu_hit) e_rd = mr;
    else if (frm)     e_rd = (num == 0) ? p : (num == 1) ? m_msr : 32'h0;
    else              e_rd = 32'h0;
    chk(tg, "rd_we", {31'b0, rd_we}, {31'b0, e_we});
    if (e_we) chk(tg, "rd_data", rd_data, e_rd);
    chk("R6", "mmu_req", {31'b0, mmu_req}, {31'b0, mmu_hit});
    if (mmu_hit) begin
      chk("R6", "mmu_we", {31'b0, mmu_we}, {31'b0, im[14]});
      chk("R6", "mmu_idx", {24'b0, mmu_idx}, {24'b0, im[7:0]});
      chk("R6", "mmu_wdata", mmu_wdata, a);
    end
    n = m_msr;
    upd = 1'b1;
    if (sc) begin
      n = cl ? (m_msr & ~b) : (m_msr | b);
    end else if (v && im[15] && im[14] && !mmu_hit && num == 1) begin
      n = a;
    end else if (rdn && rk != 2'b00) begin
      n[11] = m_msr[12];
      n[13] = m_msr[14];
      if (rk == 2'b01) n[1] = 1'b1;
      if (rk == 2'b10) n[3] = 1'b0;
      if (rk == 2'b11) begin n[8] = 1'b1; n[9] = 1'b0; end
    end else if (cw) begin
      n[31] = ci;
      n[2]  = ci;
    end else begin
      upd = 1'b0;
    end
    if (upd) n[10] = 1'b1;
    m_msr = n;
    m_chg = upd;
    m_tag = tg;
  endtask

  task automatic idle(input string tg);
    step(tg, 0, 16'h0, 0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 2'b00, 32'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sr_valid = 0; sr_imm = 0; sr_clr_sel = 0; opb = 0; ra_val = 0; cur_pc = 0;
    carry_we = 0; carry_in = 0; ret_done = 0; ret_kind = 0; mmu_rdata = 0;
    m_msr = 32'h0000_0400; m_chg = 1'b0; m_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset value checked at the first step
    idle("R1");
    // R2 set, old value out
    step("R2", 1, 16'h0000, 0, 32'h8000_0006, 0, 0, 0, 0, 0, 2'b00, 0);
    // R3 clear, forced bit survives
    step("R3", 1, 16'h0000, 1, 32'h0000_0404, 0, 0, 0, 0, 0, 2'b00, 0);
    // R4 move-to number 1
    step("R4", 1, 16'hC001, 0, 0, 32'h0000_5000, 0, 0, 0, 0, 2'b00, 0);
    // R4 move-to other number: no effect
    step("R4", 1, 16'hC003, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 2'b00, 0);
    // R5 move-from numbers 0, 1, 5
    step("R5", 1, 16'h8000, 0, 0, 0, 32'h0000_1234, 0, 0, 0, 2'b00, 0);
    step("R5", 1, 16'h8001, 0, 0, 0, 32'h0000_1234, 0, 0, 0, 2'b00, 0);
    step("R5", 1, 16'h8005, 0, 0, 0, 32'h0000_1234, 0, 0, 0, 2'b00, 0);
    // R6 MMU window edges and outside
    step("R6", 1, 16'hD007, 0, 0, 32'hA5A5_0001, 0, 0, 0, 0, 2'b00, 32'h1111_2222);
    step("R6", 1, 16'h90FF, 0, 0, 0, 0, 0, 0, 0, 2'b00, 32'hCAFE_F00D);
    step("R6", 1, 16'h9000, 0, 0, 0, 0, 0, 0, 0, 2'b00, 32'hBEEF_0000);
    step("R6", 1, 16'h9100, 0, 0, 0, 0, 0, 0, 0, 2'b00, 32'hDEAD_0000);
    step("R6", 1, 16'h8FFF, 0, 0, 0, 0, 0, 0, 0, 2'b00, 32'hDEAD_0001);
    // R7 carry writes
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1, 0, 2'b00, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0, 0, 2'b00, 0);
    // R8 interrupt return
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b01, 0);
    // R9 break return after setting bit 3 and clearing mode bits
    step("R9", 1, 16'hC001, 0, 0, 32'h0000_1208, 0, 0, 0, 0, 2'b00, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b10, 0);
    // R10 exception return, then kind 00 ignored
    step("R10", 1, 16'hC001, 0, 0, 32'h0000_4200, 0, 0, 0, 0, 2'b00, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b11, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 0);
    idle("R11");
    // R12 priority
    step("R12", 1, 16'h0000, 0, 32'h0000_0010, 0, 0, 1, 1, 1, 2'b01, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 1, 1, 1, 2'b10, 0);
    step("R12", 1, 16'h8001, 0, 0, 0, 0, 1, 1, 0, 2'b00, 0);
    // R12 random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] im;
      case ($urandom % 8)
        0: im = 16'($urandom) & 16'h7FFF;
        1: im = 16'hC001;
        2: im = 16'h8001;
        3: im = 16'h8000;
        4: im = 16'hD000 | 16'($urandom % 256);
        5: im = 16'h9000 | 16'($urandom % 256);
        6: im = 16'hC003;
        default: im = 16'($urandom);
      endcase
      step("R12", 1'(($urandom % 3) == 0), im, 1'($urandom), $urandom, $urandom, $urandom,
           1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), $urandom);
    end
    idle("R11");
    idle("R11");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule